// File: doc/BRIEF.md
# Queued Interrupt Controller for a 16-bit Core

This block is the interrupt front end of a small 16-bit processor. It keeps the interrupt handler address, a flag that makes new interrupts wait, and a ring of pending 16-bit interrupt messages. Software interrupts come from the instruction stream. Hardware interrupts come from devices. The core also sends three commands: set the handler address, set or clear the wait flag, and return from a handler.

To deliver an interrupt, a small sequencer saves the core's program counter and A register on the stack through a request/acknowledge memory port. It then hands back new values for PC, A and SP in a single write-back cycle. A return reads the two saved words back in reverse order. While the sequencer runs, `busy` keeps the core from starting its next instruction. At every instruction boundary, a waiting message is released when the wait flag is clear.

If the ring wraps onto its own unread entries, the block raises a sticky halt output.

Top module: `irqc_top`

## Requirements
- R1: While the handler address is 0x0000, a software or hardware interrupt is dropped and nothing is queued. A message that leaves the ring at a boundary while the address is zero is also dropped, so `busy` stays low.
- R2: A software interrupt accepted while queuing is off and the address is nonzero starts delivery. `busy` and `queuing` are high in the next cycle.
- R3: A software interrupt accepted while queuing is on is appended to the ring, and `busy` stays low. A hardware interrupt is appended whenever the address is nonzero, in any state.
- R4: Delivery writes the old PC to SP-1 and then the old A to SP-2. In the write-back cycle it drives PC = handler address, A = message and SP = SP-2 with `regs_we` high.
- R5: A return clears `queuing` at acceptance. It reads A from SP and then PC from SP+1, and writes back SP+2.
- R6: When `insn_boundary` is high, `busy` is low, queuing is off and the ring is not empty, the oldest message is removed and delivered. Messages leave in arrival order. A hardware message is ordered before a software message that arrives in the same cycle.
- R7: The ring has 8-bit wrapping pointers and holds at most 255 messages. A write that would make the write pointer equal the read pointer raises `halt_fire`, which stays high until reset.
- R8: The queue-control command sets `queuing` to 1 for any nonzero operand and to 0 for zero.
- R9: The address command writes the handler address, and `ia_value` shows it from the next cycle on.
- R10: `busy` is high from the cycle after acceptance through the write-back cycle. Commands and software interrupts are ignored while `busy` is high. A memory request holds its address and direction until `mem_ack`.
- R11: After reset the handler address is 0x0000, and `queuing`, `busy`, `halt_fire` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_int_valid | input | 1 | Software interrupt request |
| sw_int_msg | input | 16 | Software interrupt message |
| hw_int_valid | input | 1 | Hardware interrupt request |
| hw_int_msg | input | 16 | Hardware interrupt message |
| ias_valid | input | 1 | Write handler address |
| ias_data | input | 16 | New handler address |
| iaq_valid | input | 1 | Set queuing flag from operand |
| iaq_data | input | 16 | Queuing operand (nonzero = on) |
| rfi_valid | input | 1 | Return from handler |
| insn_boundary | input | 1 | Core is between instructions |
| core_pc | input | 16 | Current program counter |
| core_a | input | 16 | Current A register |
| core_sp | input | 16 | Current stack pointer |
| ia_value | output | 16 | Handler address (read by the core) |
| queuing | output | 1 | Queuing flag |
| busy | output | 1 | Push/pop sequence in progress |
| halt_fire | output | 1 | Sticky ring overflow halt |
| regs_we | output | 1 | Write-back strobe for PC, A, SP |
| pc_wdata | output | 16 | New PC |
| a_wdata | output | 16 | New A |
| sp_wdata | output | 16 | New SP |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Memory read data |

## Verification
A queuing flag in the wrong state shows directly on `queuing`. It also shows one cycle later as `busy` going high, or failing to, after a software interrupt. A ring pointer that has drifted shows as the wrong message in `a_wdata` three cycles after the boundary that released it, or as `halt_fire` rising before the 256th write. A corrupted saved frame shows first as a wrong `mem_addr` or `mem_wdata` in the cycle after acceptance, and then as wrong write-back values that the core model holds afterwards.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PUSH_PC,
        SQ_PUSH_A,
        SQ_POP_A,
        SQ_POP_PC,
        SQ_WB
    } seq_state_t;

    typedef struct packed {
        word_t base;     // SP at acceptance
        word_t save_pc;  // value pushed first
        word_t save_a;   // value pushed second
        word_t new_pc;
        word_t new_a;
        word_t new_sp;
    } frame_t;

    // Stack word touched by each memory step of the sequencer
    function automatic word_t step_addr(seq_state_t st, word_t base);
        case (st)
            SQ_PUSH_PC: step_addr = base - word_t'(1);
            SQ_PUSH_A:  step_addr = base - word_t'(2);
            SQ_POP_PC:  step_addr = base + word_t'(1);
            default:    step_addr = base;
        endcase
    endfunction
endpackage

// File: rtl/irqc_msg_fifo.sv
module irqc_msg_fifo #(
    parameter int PTR_W = 8,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr0_en,
    input  logic [W-1:0] wr0_data,
    input  logic         wr1_en,
    input  logic [W-1:0] wr1_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         overflow
);
    localparam int DEPTH = 1 << PTR_W;

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] head, tail, head_n, tail_n, wr1_idx;
    logic             pop;

    assign empty   = (head == tail);
    assign pop     = rd_en && !empty;
    assign rd_data = slots[tail];
    assign wr1_idx = head + PTR_W'(wr0_en);

    always_comb begin
        head_n   = head + PTR_W'(wr0_en) + PTR_W'(wr1_en);
        tail_n   = tail + PTR_W'(pop);
        overflow = (wr0_en || wr1_en) &&
                   ((head_n == tail_n) ||
                    (wr0_en && wr1_en && (head + PTR_W'(1) == tail_n)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
        end else begin
            head <= head_n;
            tail <= tail_n;
        end
    end

    always_ff @(posedge clk) begin
        if (wr0_en) slots[head]    <= wr0_data;
        if (wr1_en) slots[wr1_idx] <= wr1_data;
    end
endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_entry,
    input  logic  start_return,
    input  word_t entry_msg,
    input  word_t entry_ia,
    input  word_t core_pc,
    input  word_t core_a,
    input  word_t core_sp,
    input  logic  mem_ack,
    input  word_t mem_rdata,
    output logic  busy,
    output logic  mem_req,
    output logic  mem_we,
    output word_t mem_addr,
    output word_t mem_wdata,
    output logic  regs_we,
    output word_t pc_wdata,
    output word_t a_wdata,
    output word_t sp_wdata
);
    seq_state_t state;
    frame_t     fr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            fr    <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_entry) begin
                        fr.base    <= core_sp;
                        fr.save_pc <= core_pc;
                        fr.save_a  <= core_a;
                        fr.new_pc  <= entry_ia;
                        fr.new_a   <= entry_msg;
                        fr.new_sp  <= core_sp - word_t'(2);
                        state      <= SQ_PUSH_PC;
                    end else if (start_return) begin
                        fr.base   <= core_sp;
                        fr.new_sp <= core_sp + word_t'(2);
                        state     <= SQ_POP_A;
                    end
                end
                SQ_PUSH_PC: if (mem_ack) state <= SQ_PUSH_A;
                SQ_PUSH_A:  if (mem_ack) state <= SQ_WB;
                SQ_POP_A: if (mem_ack) begin
                    fr.new_a <= mem_rdata;
                    state    <= SQ_POP_PC;
                end
                SQ_POP_PC: if (mem_ack) begin
                    fr.new_pc <= mem_rdata;
                    state     <= SQ_WB;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != SQ_IDLE);
        mem_req   = (state == SQ_PUSH_PC) || (state == SQ_PUSH_A) ||
                    (state == SQ_POP_A)   || (state == SQ_POP_PC);
        mem_we    = (state == SQ_PUSH_PC) || (state == SQ_PUSH_A);
        mem_addr  = step_addr(state, fr.base);
        mem_wdata = (state == SQ_PUSH_PC) ? fr.save_pc : fr.save_a;
        regs_we   = (state == SQ_WB);
        pc_wdata  = fr.new_pc;
        a_wdata   = fr.new_a;
        sp_wdata  = fr.new_sp;
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_int_valid,
    input  logic [15:0] sw_int_msg,
    input  logic        hw_int_valid,
    input  logic [15:0] hw_int_msg,
    input  logic        ias_valid,
    input  logic [15:0] ias_data,
    input  logic        iaq_valid,
    input  logic [15:0] iaq_data,
    input  logic        rfi_valid,
    input  logic        insn_boundary,
    input  logic [15:0] core_pc,
    input  logic [15:0] core_a,
    input  logic [15:0] core_sp,
    output logic [15:0] ia_value,
    output logic        queuing,
    output logic        busy,
    output logic        halt_fire,
    output logic        regs_we,
    output logic [15:0] pc_wdata,
    output logic [15:0] a_wdata,
    output logic [15:0] sp_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata
);
    word_t ia_q;
    logic  queue_q, halt_q;
    logic  seq_busy, cmd_ok, ia_live;
    logic  rfi_go, sw_ok, sw_take, sw_enq, hw_enq, deq, deq_take, take;
    word_t take_msg, fifo_head_msg;
    logic  fifo_empty, fifo_ovf;

    assign cmd_ok   = !seq_busy;
    assign ia_live  = (ia_q != '0);
    assign rfi_go   = rfi_valid && cmd_ok;
    assign sw_ok    = sw_int_valid && cmd_ok && !rfi_valid && ia_live;
    assign sw_take  = sw_ok && !queue_q;
    assign sw_enq   = sw_ok && queue_q;
    assign hw_enq   = hw_int_valid && ia_live;
    assign deq      = insn_boundary && cmd_ok && !queue_q && !fifo_empty &&
                      !rfi_valid && !sw_int_valid;
    assign deq_take = deq && ia_live;
    assign take     = sw_take || deq_take;
    assign take_msg = sw_take ? sw_int_msg : fifo_head_msg;

    irqc_msg_fifo #(.PTR_W(PTR_W), .W(WORD_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr0_en   (hw_enq),
        .wr0_data (hw_int_msg),
        .wr1_en   (sw_enq),
        .wr1_data (sw_int_msg),
        .rd_en    (deq),
        .rd_data  (fifo_head_msg),
        .empty    (fifo_empty),
        .overflow (fifo_ovf)
    );

    irqc_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_entry  (take),
        .start_return (rfi_go),
        .entry_msg    (take_msg),
        .entry_ia     (ia_q),
        .core_pc      (core_pc),
        .core_a       (core_a),
        .core_sp      (core_sp),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .busy         (seq_busy),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .regs_we      (regs_we),
        .pc_wdata     (pc_wdata),
        .a_wdata      (a_wdata),
        .sp_wdata     (sp_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ia_q    <= '0;
            queue_q <= 1'b0;
            halt_q  <= 1'b0;
        end else begin
            if (ias_valid && cmd_ok) ia_q <= ias_data;
            if (rfi_go)                    queue_q <= 1'b0;
            else if (take)                 queue_q <= 1'b1;
            else if (iaq_valid && cmd_ok)  queue_q <= (iaq_data != '0);
            if (fifo_ovf) halt_q <= 1'b1;
        end
    end

    assign ia_value  = ia_q;
    assign queuing   = queue_q;
    assign busy      = seq_busy;
    assign halt_fire = halt_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic        clk,
    input logic        rst,
    input logic        sw_int_valid,
    input logic        ias_valid,
    input logic [15:0] ias_data,
    input logic        iaq_valid,
    input logic [15:0] iaq_data,
    input logic        rfi_valid,
    input logic        insn_boundary,
    input logic [15:0] ia_value,
    input logic        queuing,
    input logic        busy,
    input logic        halt_fire,
    input logic        regs_we,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        mem_ack
);
    p_ia_zero_drop_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && ia_value == 16'h0 && sw_int_valid && !rfi_valid) |=> !busy);

    p_sw_take_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rfi_valid && sw_int_valid && !queuing && ia_value != 16'h0)
        |=> (busy && queuing));

    p_sw_queued_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rfi_valid && sw_int_valid && queuing) |=> !busy);

    p_wb_in_seq_r4: assert property (@(posedge clk) disable iff (rst)
        regs_we |-> busy);

    p_rfi_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && rfi_valid) |=> (busy && !queuing));

    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        halt_fire |=> halt_fire);

    p_iaq_set_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && iaq_valid && !rfi_valid && !sw_int_valid && !insn_boundary)
        |=> (queuing == ($past(iaq_data) != 16'h0)));

    p_ias_write_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && ias_valid) |=> (ia_value == $past(ias_data)));

    p_ias_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ia_value));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind irqc_top irqc_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .sw_int_valid  (sw_int_valid),
    .ias_valid     (ias_valid),
    .ias_data      (ias_data),
    .iaq_valid     (iaq_valid),
    .iaq_data      (iaq_data),
    .rfi_valid     (rfi_valid),
    .insn_boundary (insn_boundary),
    .ia_value      (ia_value),
    .queuing       (queuing),
    .busy          (busy),
    .halt_fire     (halt_fire),
    .regs_we       (regs_we),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_ack       (mem_ack)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_int_valid = 0, hw_int_valid = 0, ias_valid = 0, iaq_valid = 0;
    logic        rfi_valid = 0, insn_boundary = 0;
    logic [15:0] sw_int_msg = 0, hw_int_msg = 0, ias_data = 0, iaq_data = 0;
    logic [15:0] core_pc, core_a, core_sp;
    logic [15:0] ia_value, pc_wdata, a_wdata, sp_wdata, mem_addr, mem_wdata, mem_rdata;
    logic        queuing, busy, halt_fire, regs_we, mem_req, mem_we, mem_ack;
    logic        ack_en = 1'b1;
    logic        ld = 1'b0;
    logic [15:0] set_pc = 0, set_a = 0, set_sp = 0;
    logic [15:0] tmem [256];
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst(rst),
        .sw_int_valid(sw_int_valid), .sw_int_msg(sw_int_msg),
        .hw_int_valid(hw_int_valid), .hw_int_msg(hw_int_msg),
        .ias_valid(ias_valid), .ias_data(ias_data),
        .iaq_valid(iaq_valid), .iaq_data(iaq_data),
        .rfi_valid(rfi_valid), .insn_boundary(insn_boundary),
        .core_pc(core_pc), .core_a(core_a), .core_sp(core_sp),
        .ia_value(ia_value), .queuing(queuing), .busy(busy), .halt_fire(halt_fire),
        .regs_we(regs_we), .pc_wdata(pc_wdata), .a_wdata(a_wdata), .sp_wdata(sp_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory and core register models
    assign mem_ack   = mem_req && ack_en;
    assign mem_rdata = tmem[mem_addr[7:0]];
    always @(posedge clk) if (mem_req && mem_ack && mem_we) tmem[mem_addr[7:0]] <= mem_wdata;
    always @(posedge clk) begin
        if (ld) begin
            core_pc <= set_pc; core_a <= set_a; core_sp <= set_sp;
        end else if (regs_we) begin
            core_pc <= pc_wdata; core_a <= a_wdata; core_sp <= sp_wdata;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic load_core(input logic [15:0] pc, input logic [15:0] a, input logic [15:0] sp);
        @(negedge clk); ld = 1; set_pc = pc; set_a = a; set_sp = sp;
        @(negedge clk); ld = 0;
    endtask

    task automatic pulse_sw(input logic [15:0] m);
        @(negedge clk); sw_int_valid = 1; sw_int_msg = m;
        @(negedge clk); sw_int_valid = 0;
    endtask

    task automatic pulse_hw(input logic [15:0] m);
        @(negedge clk); hw_int_valid = 1; hw_int_msg = m;
        @(negedge clk); hw_int_valid = 0;
    endtask

    task automatic pulse_ias(input logic [15:0] d);
        @(negedge clk); ias_valid = 1; ias_data = d;
        @(negedge clk); ias_valid = 0;
    endtask

    task automatic pulse_iaq(input logic [15:0] d);
        @(negedge clk); iaq_valid = 1; iaq_data = d;
        @(negedge clk); iaq_valid = 0;
    endtask

    task automatic pulse_rfi();
        @(negedge clk); rfi_valid = 1;
        @(negedge clk); rfi_valid = 0;
    endtask

    task automatic pulse_bnd();
        @(negedge clk); insn_boundary = 1;
        @(negedge clk); insn_boundary = 0;
    endtask

    task automatic t_reset();
        check("R11 ia", ia_value, 16'h0);
        check("R11 queuing", 16'(queuing), 16'h0);
        check("R11 busy", 16'(busy), 16'h0);
        check("R11 halt", 16'(halt_fire), 16'h0);
        check("R11 mem_req", 16'(mem_req), 16'h0);
    endtask

    task automatic t_ia_zero();
        pulse_sw(16'h0011);
        check("R1 sw dropped busy", 16'(busy), 16'h0);
        pulse_hw(16'h0022);
        pulse_ias(16'h4000);
        check("R9 ia written", ia_value, 16'h4000);
        pulse_bnd();
        check("R1 hw not queued", 16'(busy), 16'h0);
    endtask

    task automatic t_sw_take();
        load_core(16'h1234, 16'hAAAA, 16'h0000);
        pulse_sw(16'h0055);
        check("R2 busy after take", 16'(busy), 16'h1);
        check("R2 queuing after take", 16'(queuing), 16'h1);
        wait_idle();
        check("R4 pushed pc", tmem[8'hFF], 16'h1234);
        check("R4 pushed a", tmem[8'hFE], 16'hAAAA);
        check("R4 pc", core_pc, 16'h4000);
        check("R4 a", core_a, 16'h0055);
        check("R4 sp", core_sp, 16'hFFFE);
    endtask

    task automatic t_queue();
        pulse_sw(16'h0077);
        check("R3 sw queued", 16'(busy), 16'h0);
        pulse_hw(16'h0088);
        check("R3 hw queued", 16'(busy), 16'h0);
        pulse_bnd();
        check("R6 held while queuing", 16'(busy), 16'h0);
    endtask

    task automatic t_rfi();
        pulse_rfi();
        check("R5 queuing cleared", 16'(queuing), 16'h0);
        check("R5 busy", 16'(busy), 16'h1);
        wait_idle();
        check("R5 a", core_a, 16'hAAAA);
        check("R5 pc", core_pc, 16'h1234);
        check("R5 sp", core_sp, 16'h0000);
    endtask

    task automatic t_deliver();
        pulse_bnd();
        check("R6 boundary takes", 16'(busy), 16'h1);
        wait_idle();
        check("R6 first msg", core_a, 16'h0077);
        check("R6 pc from ia", core_pc, 16'h4000);
        pulse_rfi(); wait_idle();
        pulse_bnd(); wait_idle();
        check("R6 second msg", core_a, 16'h0088);
        pulse_rfi(); wait_idle();
        pulse_bnd();
        check("R6 empty no take", 16'(busy), 16'h0);
    endtask

    task automatic t_iaq();
        pulse_iaq(16'h0001);
        check("R8 iaq one", 16'(queuing), 16'h1);
        pulse_iaq(16'h0000);
        check("R8 iaq zero", 16'(queuing), 16'h0);
        pulse_iaq(16'h0100);
        check("R8 iaq high bit", 16'(queuing), 16'h1);
        pulse_iaq(16'h0000);
    endtask

    task automatic t_stall();
        ack_en = 0;
        pulse_sw(16'h0099);
        repeat (3) @(negedge clk);
        check("R10 req held", 16'(mem_req), 16'h1);
        check("R10 addr held", mem_addr, 16'hFFFF);
        check("R10 write dir", 16'(mem_we), 16'h1);
        pulse_ias(16'h1111);
        check("R10 ias ignored", ia_value, 16'h4000);
        ack_en = 1;
        wait_idle();
        check("R10 stalled delivery a", core_a, 16'h0099);
        pulse_rfi(); wait_idle();
    endtask

    task automatic t_overflow();
        pulse_iaq(16'h0001);
        @(negedge clk); hw_int_valid = 1; hw_int_msg = 16'h0123;
        repeat (255) @(negedge clk);
        hw_int_valid = 0;
        check("R7 255 stored no halt", 16'(halt_fire), 16'h0);
        pulse_hw(16'h0124);
        check("R7 256th halts", 16'(halt_fire), 16'h1);
        repeat (5) @(negedge clk);
        check("R7 halt sticky", 16'(halt_fire), 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_ia_zero();
        t_sw_take();
        t_queue();
        t_rfi();
        t_deliver();
        t_iaq();
        t_stall();
        t_overflow();
        finished = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            report();
        end
    end
endmodule